// File: doc/BRIEF.md
# Two-Level Fast/Normal Interrupt Controller

This block gathers interrupt requests from the on-chip peripherals and from a bank of general-purpose input pins. It drives two request lines into the processor core: a fast line and a normal line. The fast line outranks the normal one, and the core may pre-empt a normal handler when a fast request arrives. Software sets one steering bit per top-level source. That bit sends the source to one of the two lines and never to both. The handling of nested requests is left to the core.

Status is read in two levels. The top-level pending word has one bit per module. Each peripheral line counts as one module, and the whole pin bank counts as one more. Software reads that word first to find the module that raised the request. For the pin bank, it then reads the per-pin sticky event word to see which pin fired. Each pin can be set to trigger on a rising edge, a falling edge or both. The pins are synchronised inside the block, and their settled levels can be read back. Registers are written through a simple strobe port and read through a combinational address port.

Top module: `intc_two_level`

## Requirements
- R1: After reset `fiq` and `irq` are 0, and every register reads 0. The registers are: address 0 module enable, 1 module steering (1 = fast line), 2 module pending, 3 pin rising-edge enable, 4 pin falling-edge enable, 5 pin event status, 6 pin event enable, 7 settled pin levels. Module bits 0..NUM_SRC-1 are the `src_in` lines, and bit NUM_SRC is the pin bank.
- R2: `fiq` is 1 exactly one cycle after some module is pending, enabled and steered to 1.
- R3: `irq` is 1 exactly one cycle after some module is pending, enabled and steered to 0.
- R4: A module whose enable bit is 0 drives neither line. Its bit in the pending word (address 2) still shows its raw state.
- R5: A pin whose rising-edge enable bit is set records a 0-to-1 transition in its bit of address 5. The bit is set on the third clock edge after the pin changes.
- R6: A pin whose falling-edge enable bit is set records a 1-to-0 transition in the same way.
- R7: A pin with both edge enables set records transitions in either direction.
- R8: A transition in a direction that is not enabled for that pin leaves its status bit unchanged.
- R9: Status bits are sticky. Writing 1 to a bit at address 5 clears it, and writing 0 leaves it unchanged.
- R10: The pin-bank bit of the pending word is the OR of the status bits whose event-enable bit (address 6) is set.
- R11: The two lines are independent, so both can be 1 in the same cycle.
- R12: Address 7 returns each pin's level two clock edges after the pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_in | input | NUM_SRC | Level request lines from peripherals |
| gpio_pin | input | NUM_GPIO | General-purpose pins, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Read data, combinational, zero-extended |
| fiq | output | 1 | Fast request to the core, registered |
| irq | output | 1 | Normal request to the core, registered |

## Verification
Each result has a fixed latency:

- A register write is visible one edge after the strobe.
- A change on `src_in` or a write reaches `fiq` or `irq` one edge later, because the lines are registered.
- A pin change appears in the level register after two edges and in the status register after three.
- A pin change reaches a request line after four edges.

The driver changes inputs on the falling edge. It queues each expectation at the falling edge just before the rising edge that should produce the result. The monitor compares the queued values shortly after that rising edge, so every check lands on the cycle the latency dictates.

// File: rtl/intc_two_level.sv
`timescale 1ns/1ps
module intc_two_level #(
  parameter int NUM_SRC  = 8,
  parameter int NUM_GPIO = 28,
  parameter int DW       = 32,
  parameter int AW       = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  src_in,
  input  logic [NUM_GPIO-1:0] gpio_pin,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [DW-1:0]       wr_data,
  input  logic [AW-1:0]       rd_addr,
  output logic [DW-1:0]       rd_data,
  output logic                fiq,
  output logic                irq
);
  localparam int NMOD = NUM_SRC + 1;

  logic [NMOD-1:0]     mod_en, mod_steer, pending;
  logic [NUM_GPIO-1:0] rise_en, fall_en, gsts, gen;
  logic [NUM_GPIO-1:0] sync1, sync2, prev, edge_hit;

  assign edge_hit = (sync2 & ~prev & rise_en) | (~sync2 & prev & fall_en);
  assign pending  = {|(gsts & gen), src_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= gpio_pin;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_en    <= '0;
      mod_steer <= '0;
      rise_en   <= '0;
      fall_en   <= '0;
      gen       <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        AW'(0): mod_en    <= wr_data[NMOD-1:0];
        AW'(1): mod_steer <= wr_data[NMOD-1:0];
        AW'(3): rise_en   <= wr_data[NUM_GPIO-1:0];
        AW'(4): fall_en   <= wr_data[NUM_GPIO-1:0];
        AW'(6): gen       <= wr_data[NUM_GPIO-1:0];
        default: ;
      endcase
    end
  end

  logic [NUM_GPIO-1:0] w1c;
  assign w1c = (wr_en && wr_addr == AW'(5)) ? wr_data[NUM_GPIO-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gsts <= '0;
    else        gsts <= (gsts & ~w1c) | edge_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fiq <= 1'b0;
      irq <= 1'b0;
    end else begin
      fiq <= |(pending & mod_en & mod_steer);
      irq <= |(pending & mod_en & ~mod_steer);
    end
  end

  always_comb begin
    case (rd_addr)
      AW'(0):  rd_data = DW'(mod_en);
      AW'(1):  rd_data = DW'(mod_steer);
      AW'(2):  rd_data = DW'(pending);
      AW'(3):  rd_data = DW'(rise_en);
      AW'(4):  rd_data = DW'(fall_en);
      AW'(5):  rd_data = DW'(gsts);
      AW'(6):  rd_data = DW'(gen);
      default: rd_data = DW'(sync2);
    endcase
  end
endmodule

// File: rtl/intc_two_level_chk.sv
`timescale 1ns/1ps
module intc_two_level_chk #(
  parameter int NMOD = 9,
  parameter int NG   = 28,
  parameter int AW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NMOD-1:0] mod_en,
  input logic [NMOD-1:0] mod_steer,
  input logic [NMOD-1:0] pending,
  input logic [NG-1:0]   gsts,
  input logic [NG-1:0]   rise_en,
  input logic [NG-1:0]   fall_en,
  input logic            wr_en,
  input logic [AW-1:0]   wr_addr,
  input logic            fiq,
  input logic            irq
);
  assert_fast_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pending & mod_en & mod_steer)) |=> fiq);

  assert_normal_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pending & mod_en & ~mod_steer)) |=> irq);

  assert_disabled_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en == '0) |=> (!fiq && !irq));

  assert_sticky_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en && wr_addr == AW'(5)) |-> ((gsts & $past(gsts)) == $past(gsts)));

  assert_no_stray_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((gsts & ~$past(gsts) & ~$past(rise_en | fall_en)) == '0));
endmodule

bind intc_two_level intc_two_level_chk #(.NMOD(NUM_SRC + 1), .NG(NUM_GPIO), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .mod_steer(mod_steer),
  .pending(pending), .gsts(gsts), .rise_en(rise_en), .fall_en(fall_en),
  .wr_en(wr_en), .wr_addr(wr_addr), .fiq(fiq), .irq(irq)
);

// File: tb/test_intc_two_level.sv
`timescale 1ns/1ps
module test_intc_two_level;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  src_in = '0;
  logic [27:0] gpio_pin = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        fiq, irq;

  intc_two_level i_intc_two_level (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .gpio_pin(gpio_pin),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .fiq(fiq), .irq(irq)
  );

  always #2 clk = ~clk;

  typedef struct {
    string       req;
    int          sel;
    logic [31:0] exp;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad   = 0;
  bit done  = 0;
  localparam int LINES = 8;

  task automatic push(input string req, input int sel, input logic [31:0] exp);
    exp_t e;
    e.req = req; e.sel = sel; e.exp = exp;
    q.push_back(e);
  endtask

  task automatic nxt(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  always begin
    @(posedge clk);
    #1;
    while (q.size() > 0) begin
      exp_t e;
      logic [31:0] act;
      e = q.pop_front();
      if (e.sel == LINES) begin
        act = {30'b0, irq, fiq};
      end else begin
        rd_addr = e.sel[2:0];
        #0.1;
        act = rd_data;
      end
      total++;
      if (act !== e.exp) begin
        bad++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", e.req, e.sel, act, e.exp);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    nxt(3);
    rst_n = 1'b1;
    push("R1", LINES, 0); push("R1", 0, 0); push("R1", 1, 0);
    push("R1", 5, 0); push("R1", 7, 0);
    nxt(2);

    wr(0, 32'h3); wr(1, 32'h1);
    src_in = 8'h01;
    push("R2", LINES, 32'h1); push("R2", 2, 32'h1);
    nxt(2);
    src_in = 8'h03;
    push("R3 R11", LINES, 32'h3);
    nxt(2);
    src_in = 8'h04;
    push("R4", LINES, 32'h0); push("R4", 2, 32'h4);
    nxt(2);
    src_in = 8'h00;

    wr(3, 32'h88); wr(4, 32'hA0); wr(6, 32'h0FFF_FFFF);
    wr(0, 32'h100); wr(1, 32'h0);
    nxt(2);

    gpio_pin[3] = 1'b1;
    nxt(1); push("R12", 7, 32'h8);
    nxt(1); push("R5", 5, 32'h8); push("R10", 2, 32'h100);
    nxt(1); push("R3", LINES, 32'h2);
    nxt(2);
    wr(5, 32'h1); push("R9 keep", 5, 32'h8);
    nxt(1);
    wr(5, 32'h8); push("R9 clear", 5, 32'h0);
    nxt(1); push("R3 drop", LINES, 32'h0);
    nxt(1);

    gpio_pin[3] = 1'b0;
    nxt(4); push("R8 fall", 5, 32'h0);
    nxt(1);
    gpio_pin[5] = 1'b1;
    nxt(4); push("R8 rise", 5, 32'h0);
    nxt(1);
    gpio_pin[5] = 1'b0;
    nxt(2); push("R6", 5, 32'h20);
    nxt(1);
    wr(5, 32'h20);
    nxt(1);

    gpio_pin[7] = 1'b1;
    nxt(2); push("R7 rise", 5, 32'h80);
    nxt(1);
    wr(5, 32'h80);
    nxt(1);
    gpio_pin[7] = 1'b0;
    nxt(2); push("R7 fall", 5, 32'h80);
    nxt(3);

    wr(6, 32'h0);
    push("R10 masked", 2, 32'h0); push("R10 masked", LINES, 32'h0);
    nxt(2);
    wr(6, 32'h80); wr(1, 32'h100);
    push("R2 pin bank", LINES, 32'h1);
    nxt(3);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule